// File: doc/BRIEF.md
# Block-Ripple Lookahead Adder

A combinational adder that sums two unsigned operands and an incoming carry. The operand width is split into equal groups. Inside each group, every bit carry comes straight from a flat sum of products of the per-bit generate and propagate terms and the group's incoming carry, so no carry within a group waits on the carry below it. Between groups, the carry leaving one group becomes the carry entering the next. The longest path therefore ripples across the group boundaries only.

With the default parameters the adder is 32 bits wide, built from four 8-bit groups. The carries that cross the internal group boundaries, at bit positions 8, 16 and 24, are brought out as a port so they can be checked. The block has no clock and no reset. Its outputs follow its inputs after the combinational delay.

Top module: `adderBlockRipple`

## Requirements
- R1: `sumOut` equals the low 32 bits of the arithmetic sum `opA + opB + carryIn`, taken as unsigned numbers.
- R2: `carryOut` equals bit 32 of that same 33-bit sum.
- R3: `groupCarry[k]` (k = 0, 1, 2) equals the carry out of the partial sum of bits `8*(k+1)-1` down to 0 of both operands plus `carryIn`. That is the carry entering bit 8, 16 or 24 respectively.
- R4: With all-ones plus one (`opA` = 0xFFFFFFFF, `opB` = 1, `carryIn` = 0), `sumOut` is 0, `carryOut` is 1 and every bit of `groupCarry` is 1.
- R5: With both operands zero, `sumOut` equals `carryIn` in bit 0 and zero elsewhere, and `carryOut` and all of `groupCarry` are 0.
- R6: When `opA` is the bitwise complement of `opB`, so that the whole word propagates, `carryOut` and every bit of `groupCarry` equal `carryIn`. `sumOut` is all ones when `carryIn` is 0 and zero when it is 1.
- R7: A carry generated in the top bit of a group, with no other operand bits set (for example `opA` = `opB` = 0x80), enters the next group. The corresponding `groupCarry` bit is 1, and `sumOut` has exactly the next group's bit 0 set.
- R8: The outputs hold no state. After any change of inputs, the outputs match R1 to R3 for the new inputs within the same clock period, with no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 32 | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |
| groupCarry | output | 3 | Carries entering bits 8, 16 and 24, lowest group boundary in bit 0 |

## Verification
A faulty product term inside one group's lookahead shows up only for operand patterns that activate that term. A missing propagate factor, for example, shows up only on a run of propagating bits that ends in a generate. The bench therefore drives long propagate chains and single generates at every group's top bit, alongside random vectors. A broken link between groups appears at the next group's carry port and at every higher sum bit in the same period, because nothing is stored. A wrong carry value therefore cannot hide behind later inputs, and it is visible in the period where the inputs change.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Default geometry: four groups of eight bits.
  localparam int DEF_GROUP_W = 8;
  localparam int DEF_GROUPS  = 4;

  // Per-bit generate/propagate pair handed from the cell to the lookahead.
  typedef struct packed {
    logic gen;
    logic prop;
  } bitPgT;

endpackage

// File: rtl/claGenProp.sv
module claGenProp
  import cla_pkg::*;
#(
  parameter int WIDTH = DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output bitPgT [WIDTH-1:0] pgOut,
  output logic [WIDTH-1:0] halfSum
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      // Generate: both bits set; propagate: either bit set.
      assign pgOut[i].gen  = opA[i] & opB[i];
      assign pgOut[i].prop = opA[i] | opB[i];
      assign halfSum[i]    = opA[i] ^ opB[i];
    end
  endgenerate

endmodule

// File: rtl/claLookahead.sv
module claLookahead
  import cla_pkg::*;
#(
  parameter int WIDTH = DEF_GROUP_W
) (
  input  bitPgT [WIDTH-1:0] pgIn,
  input  logic             carryIn,
  output logic [WIDTH:0]   carries
);

  // Each carry is a flat OR of product terms. None of them reads another carry.
  logic accTerm;
  logic runTerm;
  logic cinTerm;

  always_comb begin
    carries    = '0;
    carries[0] = carryIn;
    accTerm    = 1'b0;
    runTerm    = 1'b0;
    cinTerm    = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      accTerm = pgIn[i].gen;
      for (int j = 0; j < i; j++) begin
        runTerm = pgIn[j].gen;
        for (int k = j + 1; k <= i; k++) begin
          runTerm = runTerm & pgIn[k].prop;
        end
        accTerm = accTerm | runTerm;
      end
      cinTerm = carryIn;
      for (int k = 0; k <= i; k++) begin
        cinTerm = cinTerm & pgIn[k].prop;
      end
      carries[i+1] = accTerm | cinTerm;
    end
  end

endmodule

// File: rtl/claGroup.sv
module claGroup
  import cla_pkg::*;
#(
  parameter int WIDTH = DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  bitPgT [WIDTH-1:0] pgBits;
  logic  [WIDTH-1:0] halfSum;
  logic  [WIDTH:0]   carries;

  claGenProp #(.WIDTH(WIDTH)) u_pg (
    .opA     (opA),
    .opB     (opB),
    .pgOut   (pgBits),
    .halfSum (halfSum)
  );

  claLookahead #(.WIDTH(WIDTH)) u_la (
    .pgIn    (pgBits),
    .carryIn (carryIn),
    .carries (carries)
  );

  assign sumOut   = halfSum ^ carries[WIDTH-1:0];
  assign carryOut = carries[WIDTH];

endmodule

// File: rtl/adderBlockRipple.sv
module adderBlockRipple
  import cla_pkg::*;
#(
  parameter int GROUP_W = DEF_GROUP_W,
  parameter int GROUPS  = DEF_GROUPS
) (
  input  logic [GROUP_W*GROUPS-1:0] opA,
  input  logic [GROUP_W*GROUPS-1:0] opB,
  input  logic                      carryIn,
  output logic [GROUP_W*GROUPS-1:0] sumOut,
  output logic                      carryOut,
  output logic [GROUPS-2:0]         groupCarry
);

  localparam int TOTAL_W = GROUP_W * GROUPS;

  // Carry entering each group; the last entry leaves the top group.
  logic [GROUPS:0] chain;

  assign chain[0] = carryIn;

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      claGroup #(.WIDTH(GROUP_W)) u_grp (
        .opA      (opA[g*GROUP_W +: GROUP_W]),
        .opB      (opB[g*GROUP_W +: GROUP_W]),
        .carryIn  (chain[g]),
        .sumOut   (sumOut[g*GROUP_W +: GROUP_W]),
        .carryOut (chain[g+1])
      );
    end
  endgenerate

  assign groupCarry = chain[GROUPS-1:1];
  assign carryOut   = chain[GROUPS];

endmodule

// File: rtl/adderBlockRipple_chk.sv
module adderBlockRipple_chk #(
  parameter int GROUP_W = 8,
  parameter int GROUPS  = 4
) (
  input logic [GROUP_W*GROUPS-1:0] opA,
  input logic [GROUP_W*GROUPS-1:0] opB,
  input logic                      carryIn,
  input logic [GROUP_W*GROUPS-1:0] sumOut,
  input logic                      carryOut,
  input logic [GROUPS-2:0]         groupCarry
);

  localparam int TOTAL_W = GROUP_W * GROUPS;

  logic [TOTAL_W:0] wideSum;
  assign wideSum = {1'b0, opA} + {1'b0, opB} + {{TOTAL_W{1'b0}}, carryIn};

  always_comb begin
    // R1
    sum_value_chk: assert (sumOut == wideSum[TOTAL_W-1:0])
      else $error("sum mismatch");
    // R2
    carry_out_chk: assert (carryOut == wideSum[TOTAL_W])
      else $error("carry out mismatch");
    // R5
    zero_operand_chk: assert (!((opA == '0) && (opB == '0)) ||
                              (!carryOut && groupCarry == '0))
      else $error("zero operands produced a carry");
    // R6
    chain_chk: assert (!((opA ^ opB) == {TOTAL_W{1'b1}}) ||
                       (carryOut == carryIn &&
                        groupCarry == {(GROUPS-1){carryIn}}))
      else $error("propagate chain broken");
  end

  genvar k;
  generate
    for (k = 0; k < GROUPS - 1; k++) begin : g_bnd
      logic [GROUP_W*(k+1):0] partSum;
      assign partSum = {1'b0, opA[GROUP_W*(k+1)-1:0]} +
                       {1'b0, opB[GROUP_W*(k+1)-1:0]} +
                       {{(GROUP_W*(k+1)){1'b0}}, carryIn};
      always_comb begin
        // R3
        group_carry_chk: assert (groupCarry[k] == partSum[GROUP_W*(k+1)])
          else $error("group boundary carry mismatch");
      end
    end
  endgenerate

endmodule

bind adderBlockRipple adderBlockRipple_chk #(
  .GROUP_W (GROUP_W),
  .GROUPS  (GROUPS)
) u_chk (
  .opA        (opA),
  .opB        (opB),
  .carryIn    (carryIn),
  .sumOut     (sumOut),
  .carryOut   (carryOut),
  .groupCarry (groupCarry)
);

// File: tb/adderBlockRipple_tb.sv
`timescale 1ns/1ps
module adderBlockRipple_tb;

  localparam int GW = 8;
  localparam int NG = 4;
  localparam int TW = GW * NG;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [TW-1:0] opA = '0;
  logic [TW-1:0] opB = '0;
  logic          carryIn = 1'b0;
  logic [TW-1:0] sumOut;
  logic          carryOut;
  logic [NG-2:0] groupCarry;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  adderBlockRipple #(.GROUP_W(GW), .GROUPS(NG)) u_dut (
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .sumOut     (sumOut),
    .carryOut   (carryOut),
    .groupCarry (groupCarry)
  );

  task automatic note(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive after the edge, check mid-period against 64-bit arithmetic (R1, R2, R3, R8).
  task automatic applyVec(input logic [TW-1:0] a, input logic [TW-1:0] b, input logic c);
    longint unsigned full, part, mask;
    @(posedge clk);
    #0.5;
    opA = a; opB = b; carryIn = c;
    #1;
    full = longint'(a) + longint'(b) + longint'(c);
    note(sumOut == full[TW-1:0], "R1", longint'(sumOut), longint'(full[TW-1:0]));
    note(carryOut == full[TW], "R2", longint'(carryOut), longint'(full[TW]));
    for (int k = 0; k < NG - 1; k++) begin
      mask = (64'd1 << (GW * (k + 1))) - 1;
      part = (longint'(a) & mask) + (longint'(b) & mask) + longint'(c);
      note(groupCarry[k] == part[GW*(k+1)], "R3",
           longint'(groupCarry[k]), longint'(part[GW*(k+1)]));
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // Initial state with zero inputs: R5
    @(posedge clk);
    #1.5;
    note(sumOut == '0 && !carryOut && groupCarry == '0, "R5", longint'(sumOut), 0);

    // R4: all ones plus one
    applyVec('1, 32'd1, 1'b0);
    note(sumOut == '0 && carryOut && groupCarry == 3'b111, "R4",
         longint'({carryOut, groupCarry, sumOut}), longint'({1'b1, 3'b111, 32'd0}));

    // R5: zeros with carry-in set
    applyVec('0, '0, 1'b1);
    note(sumOut == 32'd1 && !carryOut && groupCarry == '0, "R5",
         longint'(sumOut), 1);

    // R6: full propagate chains across every boundary
    for (int n = 0; n < 40; n++) begin
      logic [TW-1:0] r;
      r = $urandom;
      applyVec(r, ~r, n[0]);
      note(carryOut == n[0] && groupCarry == {3{n[0]}} &&
           sumOut == (n[0] ? 32'd0 : 32'hFFFF_FFFF), "R6",
           longint'({carryOut, groupCarry, sumOut}),
           longint'({n[0], {3{n[0]}}, (n[0] ? 32'd0 : 32'hFFFF_FFFF)}));
    end

    // R7: generate in the top bit of each lower group
    for (int k = 0; k < NG - 1; k++) begin
      logic [TW-1:0] v;
      v = 32'd1 << (GW * (k + 1) - 1);
      applyVec(v, v, 1'b0);
      note(groupCarry == (3'b1 << k) && sumOut == (32'd1 << (GW * (k + 1))), "R7",
           longint'({groupCarry, sumOut}),
           longint'({3'b1 << k, 32'd1 << (GW * (k + 1))}));
    end

    // Generate at the low end of a propagate run that reaches each boundary
    for (int k = 0; k < NG - 1; k++) begin
      logic [TW-1:0] run;
      run = (32'd1 << (GW * (k + 1))) - 1;
      applyVec(run, 32'd1, 1'b0);
      applyVec(run ^ 32'd1, 32'd1, 1'b1);
    end

    // R8: random vectors, each independent of the previous one
    for (int n = 0; n < 12000; n++) begin
      applyVec($urandom, $urandom, 1'($urandom));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule